// File: doc/BRIEF.md
# Word Multiply Unit with Overflow and Condition Flags

This block executes the 32-bit multiply-word operations of an integer pipeline. It covers a low-word multiply and a high-word multiply, and the high-word multiply can be signed or unsigned. Both operands are widened by one bit, so a single signed multiplier serves the signed and the unsigned forms. The product is registered once. The second pipeline stage reads that register directly, so there is no busy or handshake logic.

In the second stage the unit selects the result word and works out an overflow indication. It updates the overflow, overflow-32 and sticky summary-overflow bits, and it builds a 4-bit condition field from the selected result. A stall input freezes the stage register. A flush input cancels the instruction in the second stage together with all of its flag updates.

Top module: `wordmul_unit`

## Requirements
- R1: Each operand is widened to 33 bits. The upper bit is the operand's bit 31 when `is_signed` is 1 and 0 otherwise. The product is therefore the true signed or the true unsigned product of the two 32-bit values.
- R2: `out_valid` equals `in_valid` as captured at the previous clock edge where `stall` was 0. The result belongs to that same capture, so the latency is exactly one enabled cycle.
- R3: While `stall` is 1, the stored product and its valid bit keep their values, and the outputs do not change.
- R4: When `high_sel` is 0, `result` is the low 64 bits of the product.
- R5: When `high_sel` is 1, `result[63:32]` and `result[31:0]` both hold product bits 63..32.
- R6: The overflow indication is 1 exactly when product bits 63..31 are neither all zeros nor all ones.
- R7: When `ovf_en` is 1 and the instruction is live, `xer_we` is 1, `ov_out` and `ov32_out` equal the overflow indication, and `so_out` is `so_in` ORed with it. When `ovf_en` is 0, `xer_we` is 0, `ov_out` and `ov32_out` are 0, and `so_out` equals `so_in`.
- R8: When `rec_en` is 1 and the instruction is live, `cr_we` is 1. The condition field is encoded as bit 3 = result bit 63 (negative), bit 2 = positive (neither negative nor zero), bit 1 = all 64 result bits are zero, and bit 0 = `so_out`.
- R9: While `flush` is 1, `out_valid`, `xer_we` and `cr_we` are 0. A flush during a stall also clears the stored valid bit, so the instruction is gone once the flush ends.
- R10: After reset, `out_valid`, `xer_we` and `cr_we` are 0 and `result` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stall | input | 1 | Freezes the stage register |
| flush | input | 1 | Cancels the second-stage instruction |
| in_valid | input | 1 | Operands are valid this cycle |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| is_signed | input | 1 | Treat operands as signed |
| high_sel | input | 1 | 1 selects the high word, 0 selects the low product |
| ovf_en | input | 1 | Enable overflow flag update |
| rec_en | input | 1 | Enable condition field update |
| so_in | input | 1 | Current summary-overflow bit |
| out_valid | output | 1 | Second-stage result is valid |
| result | output | 64 | Selected result |
| ov_out | output | 1 | Overflow bit |
| ov32_out | output | 1 | 32-bit overflow bit |
| so_out | output | 1 | Updated summary-overflow bit |
| xer_we | output | 1 | Write enable for the overflow bits |
| cr_field | output | 4 | Condition field {neg, pos, zero, so} |
| cr_we | output | 1 | Write enable for the condition field |

## Verification
The assertions assume that `stall`, `flush` and all data inputs are driven to known values at every clock edge once reset is released. They also assume that `so_in` is presented together with the operands, because the unit captures it at the same edge. The stimulus changes inputs only on falling edges and keeps every input defined from time zero. It uses flush only while the instruction to be cancelled sits in the second stage, so every check on the flag enables falls inside these assumptions.

// File: rtl/wordmul_unit.sv
module wordmul_unit #(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           stall,
  input  logic           flush,
  input  logic           in_valid,
  input  logic [W-1:0]   op_a,
  input  logic [W-1:0]   op_b,
  input  logic           is_signed,
  input  logic           high_sel,
  input  logic           ovf_en,
  input  logic           rec_en,
  input  logic           so_in,
  output logic           out_valid,
  output logic [2*W-1:0] result,
  output logic           ov_out,
  output logic           ov32_out,
  output logic           so_out,
  output logic           xer_we,
  output logic [3:0]     cr_field,
  output logic           cr_we
);
  localparam int PW = 2 * W;

  logic signed [PW-1:0] wide_a, wide_b;
  logic        [PW-1:0] prod_c;

  assign wide_a = {{(W-1){op_a[W-1] & is_signed}}, op_a[W-1] & is_signed, op_a};
  assign wide_b = {{(W-1){op_b[W-1] & is_signed}}, op_b[W-1] & is_signed, op_b};
  assign prod_c = wide_a * wide_b;

  logic          r_valid, r_high, r_oe, r_rc, r_so;
  logic [PW-1:0] r_prod;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      r_valid <= 1'b0;
      r_prod  <= '0;
      r_high  <= 1'b0;
      r_oe    <= 1'b0;
      r_rc    <= 1'b0;
      r_so    <= 1'b0;
    end else if (stall) begin
      r_valid <= r_valid & ~flush;
    end else begin
      r_valid <= in_valid;
      r_prod  <= prod_c;
      r_high  <= high_sel;
      r_oe    <= ovf_en;
      r_rc    <= rec_en;
      r_so    <= so_in;
    end
  end

  logic [W-1:0] hi_word;
  logic         ovf, live, so_new, is_zero, is_neg;

  assign hi_word   = r_prod[PW-1:W];
  assign result    = r_high ? {hi_word, hi_word} : r_prod;
  assign ovf       = (|r_prod[PW-1:W-1]) & ~(&r_prod[PW-1:W-1]);
  assign live      = r_valid & ~flush;
  assign so_new    = r_so | (r_oe & ovf);

  assign out_valid = live;
  assign ov_out    = r_oe & ovf;
  assign ov32_out  = r_oe & ovf;
  assign so_out    = so_new;
  assign xer_we    = live & r_oe;

  assign is_zero   = ~|result;
  assign is_neg    = result[PW-1];
  assign cr_field  = {is_neg, ~(is_neg | is_zero), is_zero, so_new};
  assign cr_we     = live & r_rc;

  assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !stall |=> (r_valid == $past(in_valid)));

  assert_stall_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && !flush) |=> ($stable(r_prod) && $stable(r_valid)));

  assert_high_dup_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && r_high) |-> (result[PW-1:W] == result[W-1:0]));

  assert_so_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (xer_we && ov_out) |-> so_out);

  assert_so_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !r_oe |-> (so_out == r_so && !xer_we));

  assert_cr_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cr_we |-> ($countones(cr_field[3:1]) == 1 && cr_field[0] == so_out));

  assert_flush_kill_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (!out_valid && !xer_we && !cr_we));
endmodule

// File: tb/test_wordmul_unit.sv
module test_wordmul_unit;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        stall = 1'b0, flush = 1'b0, in_valid = 1'b0;
  logic [31:0] op_a = '0, op_b = '0;
  logic        is_signed = 1'b0, high_sel = 1'b0, ovf_en = 1'b0, rec_en = 1'b0, so_in = 1'b0;
  logic        out_valid, ov_out, ov32_out, so_out, xer_we, cr_we;
  logic [63:0] result;
  logic [3:0]  cr_field;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wordmul_unit i_wordmul_unit (
    .clk(clk), .rst_n(rst_n), .stall(stall), .flush(flush), .in_valid(in_valid),
    .op_a(op_a), .op_b(op_b), .is_signed(is_signed), .high_sel(high_sel),
    .ovf_en(ovf_en), .rec_en(rec_en), .so_in(so_in),
    .out_valid(out_valid), .result(result), .ov_out(ov_out), .ov32_out(ov32_out),
    .so_out(so_out), .xer_we(xer_we), .cr_field(cr_field), .cr_we(cr_we)
  );

  // {a, b, signed, high, ovf_en, rec_en, so_in}
  localparam logic [68:0] VEC [NV] = '{
    {32'h0000_0003, 32'h0000_0005, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0},
    {32'hFFFF_FFFF, 32'h0000_0002, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0},
    {32'hFFFF_FFFF, 32'h0000_0002, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0},
    {32'h8000_0000, 32'h8000_0000, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0},
    {32'h0000_0000, 32'h0001_2345, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1},
    {32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0},
    {32'h7FFF_FFFF, 32'hFFFF_FFFF, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0},
    {32'h0001_0000, 32'h0001_0000, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R10 reset state
    check("R10 out_valid", {63'b0, out_valid}, 64'd0);
    check("R10 result", result, 64'd0);
    check("R10 enables", {62'b0, xer_we, cr_we}, 64'd0);

    for (int i = 0; i < NV; i++) begin
      logic [63:0] prod, exp_res;
      logic [32:0] top;
      logic        ovf, so_e, neg, zer;
      {op_a, op_b, is_signed, high_sel, ovf_en, rec_en, so_in} = VEC[i];
      in_valid = 1'b1;
      if (is_signed) prod = 64'($signed(op_a)) * 64'($signed(op_b));
      else           prod = {32'b0, op_a} * {32'b0, op_b};
      exp_res = high_sel ? {prod[63:32], prod[63:32]} : prod;
      top  = prod[63:31];
      ovf  = !(top == '0 || top == '1);
      so_e = so_in | (ovf_en & ovf);
      neg  = exp_res[63];
      zer  = (exp_res == 0);
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      check("R2 out_valid", {63'b0, out_valid}, 64'd1);
      check(high_sel ? "R5 high result (R1 ext)" : "R4 low result (R1 ext)", result, exp_res);
      check("R6 ov_out", {63'b0, ov_out}, {63'b0, ovf_en & ovf});
      check("R7 ov32_out", {63'b0, ov32_out}, {63'b0, ovf_en & ovf});
      check("R7 so_out", {63'b0, so_out}, {63'b0, so_e});
      check("R7 xer_we", {63'b0, xer_we}, {63'b0, ovf_en});
      check("R8 cr_field", {60'b0, cr_field}, {60'b0, neg, !(neg | zer), zer, so_e});
      check("R8 cr_we", {63'b0, cr_we}, {63'b0, rec_en});
    end

    // R2 idle cycle gives no valid
    @(posedge clk);
    @(negedge clk);
    check("R2 idle out_valid", {63'b0, out_valid}, 64'd0);

    // R3 stall holds the result
    {op_a, op_b, is_signed, high_sel, ovf_en, rec_en, so_in} = {32'd6, 32'd7, 5'b10000};
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R3 before stall", result, 64'd42);
    stall = 1'b1;
    op_a = 32'd2;
    op_b = 32'd2;
    @(posedge clk);
    @(negedge clk);
    check("R3 held result", result, 64'd42);
    check("R3 held valid", {63'b0, out_valid}, 64'd1);
    stall = 1'b0;
    in_valid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R2 after stall release", {63'b0, out_valid}, 64'd0);

    // R9 flush kills the second-stage instruction
    {op_a, op_b, is_signed, high_sel, ovf_en, rec_en, so_in} = {32'd9, 32'd9, 5'b10110};
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    stall = 1'b1;
    flush = 1'b1;
    #1;
    check("R9 flush out_valid", {63'b0, out_valid}, 64'd0);
    check("R9 flush enables", {62'b0, xer_we, cr_we}, 64'd0);
    @(posedge clk);
    @(negedge clk);
    flush = 1'b0;
    #1;
    check("R9 cleared after flush", {63'b0, out_valid}, 64'd0);
    stall = 1'b0;
    @(posedge clk);
    @(negedge clk);

    finish_run();
  end
endmodule